// File: doc/BRIEF.md
# ACPI Power-Management Event Register Block

This block holds the fixed power-management event registers that system software polls and acknowledges: an event status register, an event enable register, a control register and a free-running power-management timer. All four sit inside a 16-byte I/O window. Software reaches them over a simple I/O bus that carries a dword-aligned address, four byte enables and 32-bit write data. The bus returns 32-bit read data combinationally in the same cycle. Byte, word and dword accesses are all expressed through the byte enables, so byte offset k of a register's dword slot travels on byte lane k.

Hardware events arrive as single-cycle pulses: power button, RTC alarm, bus-master activity and global release. The timer also reports its own overflow. It advances on a tick-enable pulse from an external prescaler running at about 3.58 MHz. Each event sets a sticky status bit. Software clears a status bit by writing a one to it. A level system-control interrupt (`sci`) is raised while interrupts are globally enabled and at least one enabled event is pending.

The read path is a small decoder keyed by an enumerated slot type. There is one slot for the event pair, one for control, one for the timer and a reserved slot.

Top module: `acpi_pm_regs`

## Requirements
- R1: After reset, status reads 0x0000, enable reads 0x0000, the timer reads 0 and control reads 0x0001, with only the interrupt-enable bit (control bit 0) set.
- R2: io_addr[3:2] selects a dword slot. Slot 0 (offset 0) returns enable in bits 31:16 and status in bits 15:0. Slot 1 (offset 4) returns control in bits 15:0 with bits 31:16 zero. Slot 2 (offset 8) returns the timer. Slot 3 returns 0. An access whose io_addr[1:0] is not 00 writes nothing and reads 0.
- R3: A write changes only the byte lanes whose io_be bit is 1. Enable uses lanes 2 and 3 of slot 0, and control uses lanes 0 and 1 of slot 1.
- R4: A write to status lanes (slot 0, lanes 0 and 1) clears every status bit written as 1 and leaves bits written as 0 unchanged. An event pulse in the same cycle as a clear of its bit wins, so the bit stays set.
- R5: Event pulses set sticky status bits: power button sets bit 8, RTC sets bit 10, bus master sets bit 4 and global release sets bit 5. Status bits with no source always read 0.
- R6: A dword write at offset 0 (io_be = 1111) applies write-one-to-clear to status from bits 15:0 and loads enable from bits 31:16 in the same cycle.
- R7: The timer increments by one on each cycle with tmr_tick high and wraps at its width. Writes to the timer slot have no effect.
- R8: Status bit 0 is set on the cycle after any increment that toggles timer bit OVF_BIT (default 23), in either direction.
- R9: sci is high exactly while control bit 0 is 1 and some status bit among 0, 5, 8 and 10 is set together with the same enable bit. Status bit 4 never raises sci.
- R10: irq_line reports the interrupt line number, 9 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Bus access strobe |
| io_wr | input | 1 | 1 for a write, 0 for a read |
| io_addr | input | 4 | Byte address inside the 16-byte window |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the access cycle |
| tmr_tick | input | 1 | Timer tick enable from the prescaler |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | RTC alarm event pulse |
| evt_busmst | input | 1 | Bus-master activity pulse |
| evt_gbl_rls | input | 1 | Global-release event pulse |
| sci | output | 1 | Level system-control interrupt |
| irq_line | output | 8 | Reported interrupt line number |

## Verification
A corrupted status or enable bit reaches the ports in two ways. It shows on io_rdata at the next read of offset 0. Where the bit is one of the interrupt sources, sci also changes on the cycle after the faulty edge. A wrong clear/set priority appears when a read of offset 0 follows the colliding write. A timer fault appears as a wrong count at offset 8 after the ticks, and as status bit 0 being set one tick early or late around the toggle of the overflow bit. The checks therefore read back after every stimulus and sample sci on the cycle after each event, clear or enable change.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;
    localparam int REG_W  = 16;
    localparam int BUS_W  = 32;
    localparam int LANES  = REG_W / 8;

    // status bit positions, decoded by software
    localparam int STS_TMR    = 0;
    localparam int STS_BM     = 4;
    localparam int STS_GBL    = 5;
    localparam int STS_PWRBTN = 8;
    localparam int STS_RTC    = 10;

    localparam int CTL_SCI_EN = 0;

    localparam logic [REG_W-1:0] SCI_SRC_MASK = REG_W'((1 << STS_TMR) | (1 << STS_GBL) |
                                                       (1 << STS_PWRBTN) | (1 << STS_RTC));
    localparam logic [REG_W-1:0] CTL_RESET    = REG_W'(1 << CTL_SCI_EN);

    typedef enum logic [1:0] {
        SLOT_EVT = 2'd0,
        SLOT_CTL = 2'd1,
        SLOT_TMR = 2'd2,
        SLOT_RSV = 2'd3
    } slot_e;
endpackage

// File: rtl/acpi_pm_timer.sv
module acpi_pm_timer #(
    parameter int TMR_W   = 32,
    parameter int OVF_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] cnt_q,
    output logic             ovf_pulse
);
    // the watched bit flips exactly when every bit below it is one on an increment
    assign ovf_pulse = tick && (&cnt_q[OVF_BIT-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + TMR_W'(1);
    end

    // R7
    tmr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + TMR_W'(1)));

    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/acpi_pm_evt.sv
module acpi_pm_evt
    import acpi_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [REG_W-1:0] hw_set,
    input  logic [LANES-1:0] en_lane_we,
    input  logic [REG_W-1:0] en_wdata,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] en_q
);
    // set dominates clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_mask) | hw_set;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_en_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[8*g +: 8] <= '0;
            else if (en_lane_we[g])
                en_q[8*g +: 8] <= en_wdata[8*g +: 8];
        end
    end

    // R4
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[STS_GBL] && !hw_set[STS_GBL]) |=> !stat_q[STS_GBL]);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[STS_PWRBTN] |=> stat_q[STS_PWRBTN]);

    // R5
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[STS_RTC] && !clr_mask[STS_RTC]) |=> stat_q[STS_RTC]);
endmodule

// File: rtl/acpi_pm_regs.sv
module acpi_pm_regs
    import acpi_pm_pkg::*;
#(
    parameter int          TMR_W    = 32,
    parameter int          OVF_BIT  = 23,
    parameter logic [7:0]  IRQ_LINE = 8'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_sel,
    input  logic             io_wr,
    input  logic [3:0]       io_addr,
    input  logic [3:0]       io_be,
    input  logic [BUS_W-1:0] io_wdata,
    output logic [BUS_W-1:0] io_rdata,
    input  logic             tmr_tick,
    input  logic             evt_pwrbtn,
    input  logic             evt_rtc,
    input  logic             evt_busmst,
    input  logic             evt_gbl_rls,
    output logic             sci,
    output logic [7:0]       irq_line
);
    slot_e            slot;
    logic             acc_ok;
    logic             wr_go;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] hw_set;
    logic [LANES-1:0] en_lane_we;
    logic [LANES-1:0] ctl_lane_we;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] ctrl_q;
    logic [TMR_W-1:0] tmr_q;
    logic             ovf_pulse;

    assign slot   = slot_e'(io_addr[3:2]);
    assign acc_ok = io_sel && (io_addr[1:0] == 2'b00);
    assign wr_go  = acc_ok && io_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
        assign clr_mask[8*g +: 8] = (wr_go && slot == SLOT_EVT && io_be[g]) ?
                                    io_wdata[8*g +: 8] : 8'h00;
        assign en_lane_we[g]      = wr_go && slot == SLOT_EVT && io_be[LANES+g];
        assign ctl_lane_we[g]     = wr_go && slot == SLOT_CTL && io_be[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[8*g +: 8] <= CTL_RESET[8*g +: 8];
            else if (ctl_lane_we[g])
                ctrl_q[8*g +: 8] <= io_wdata[8*g +: 8];
        end
    end

    always_comb begin
        hw_set             = '0;
        hw_set[STS_TMR]    = ovf_pulse;
        hw_set[STS_BM]     = evt_busmst;
        hw_set[STS_GBL]    = evt_gbl_rls;
        hw_set[STS_PWRBTN] = evt_pwrbtn;
        hw_set[STS_RTC]    = evt_rtc;
    end

    acpi_pm_timer #(
        .TMR_W   (TMR_W),
        .OVF_BIT (OVF_BIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tmr_tick),
        .cnt_q     (tmr_q),
        .ovf_pulse (ovf_pulse)
    );

    acpi_pm_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_mask   (clr_mask),
        .hw_set     (hw_set),
        .en_lane_we (en_lane_we),
        .en_wdata   (io_wdata[BUS_W-1:REG_W]),
        .stat_q     (stat_q),
        .en_q       (en_q)
    );

    always_comb begin
        io_rdata = '0;
        if (acc_ok && !io_wr) begin
            unique case (slot)
                SLOT_EVT: io_rdata = {en_q, stat_q};
                SLOT_CTL: io_rdata = {{(BUS_W-REG_W){1'b0}}, ctrl_q};
                SLOT_TMR: io_rdata = BUS_W'(tmr_q);
                SLOT_RSV: io_rdata = '0;
            endcase
        end
    end

    assign sci      = ctrl_q[CTL_SCI_EN] && |(stat_q & en_q & SCI_SRC_MASK);
    assign irq_line = IRQ_LINE;

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> stat_q[STS_TMR]);

    // R9
    sci_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> ctrl_q[CTL_SCI_EN]);

    // R7
    tmr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && slot == SLOT_TMR && !tmr_tick) |=> $stable(tmr_q));
endmodule

// File: tb/test_acpi_pm_regs.sv
module test_acpi_pm_regs;
    localparam int OVF = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_sel, io_wr;
    logic [3:0]  io_addr, io_be;
    logic [31:0] io_wdata;
    logic [31:0] io_rdata;
    logic        tmr_tick, evt_pwrbtn, evt_rtc, evt_busmst, evt_gbl_rls;
    logic        sci;
    logic [7:0]  irq_line;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    acpi_pm_regs #(.OVF_BIT(OVF)) i_acpi_pm_regs (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
        .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .tmr_tick(tmr_tick),
        .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_busmst(evt_busmst),
        .evt_gbl_rls(evt_gbl_rls), .sci(sci), .irq_line(irq_line)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        io_sel = 1; io_wr = 1; io_addr = a; io_be = be; io_wdata = d;
        @(negedge clk);
        io_sel = 0; io_wr = 0; io_be = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        io_sel = 1; io_wr = 0; io_addr = a; io_be = 4'hF;
        #1;
        chk(tag, io_rdata, exp);
        io_sel = 0; io_be = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tmr_tick = 1;
        repeat (n) @(negedge clk);
        tmr_tick = 0;
    endtask

    task automatic sci_chk(input string tag, input logic exp);
        @(negedge clk);
        #1;
        chk(tag, {31'b0, sci}, {31'b0, exp});
    endtask

    task automatic t_reset();
        rd_chk("R1 status/enable after reset", 4'h0, 32'h0000_0000);
        rd_chk("R1 control after reset", 4'h4, 32'h0000_0001);
        rd_chk("R1 timer after reset", 4'h8, 32'h0);
        rd_chk("R2 reserved slot", 4'hC, 32'h0);
        chk("R10 irq line", {24'b0, irq_line}, 32'd9);
        sci_chk("R9 sci low after reset", 1'b0);
    endtask

    task automatic t_timer();
        bus_wr(4'h8, 4'hF, 32'hDEAD_BEEF);
        rd_chk("R7 timer write ignored", 4'h8, 32'h0);
        ticks(5);
        rd_chk("R7 timer counts ticks", 4'h8, 32'd5);
        ticks(58);
        rd_chk("R8 no overflow before toggle", 4'h0, 32'h0);
        ticks(1);
        rd_chk("R8 overflow on rising toggle", 4'h0, 32'h0000_0001);
        bus_wr(4'h0, 4'h1, 32'h1);
        rd_chk("R4 overflow status cleared", 4'h0, 32'h0);
        ticks(63);
        rd_chk("R8 no overflow at 127", 4'h0, 32'h0);
        ticks(1);
        rd_chk("R8 overflow on falling toggle", 4'h0, 32'h0000_0001);
        rd_chk("R7 timer at 128", 4'h8, 32'd128);
        bus_wr(4'h0, 4'h3, 32'hFFFF);
    endtask

    task automatic pulse_pwr();
        @(negedge clk); evt_pwrbtn = 1; @(negedge clk); evt_pwrbtn = 0;
    endtask
    task automatic pulse_rtc();
        @(negedge clk); evt_rtc = 1; @(negedge clk); evt_rtc = 0;
    endtask
    task automatic pulse_bm();
        @(negedge clk); evt_busmst = 1; @(negedge clk); evt_busmst = 0;
    endtask
    task automatic pulse_gbl();
        @(negedge clk); evt_gbl_rls = 1; @(negedge clk); evt_gbl_rls = 0;
    endtask

    task automatic t_events();
        pulse_pwr();
        rd_chk("R5 power button sets bit 8", 4'h0, 32'h0000_0100);
        sci_chk("R9 disabled event gives no sci", 1'b0);
        pulse_rtc(); pulse_bm(); pulse_gbl();
        rd_chk("R5 rtc/bm/gbl set bits 10/4/5", 4'h0, 32'h0000_0530);
    endtask

    task automatic t_w1c();
        bus_wr(4'h0, 4'h2, 32'h0000_0100);
        rd_chk("R4 clear bit 8 by byte write", 4'h0, 32'h0000_0430);
        bus_wr(4'h0, 4'h3, 32'h0000_0000);
        rd_chk("R4 zeros leave status", 4'h0, 32'h0000_0430);
        @(negedge clk);
        evt_rtc = 1; io_sel = 1; io_wr = 1; io_addr = 4'h0; io_be = 4'h2; io_wdata = 32'h0000_0400;
        @(negedge clk);
        evt_rtc = 0; io_sel = 0; io_wr = 0; io_be = 0;
        rd_chk("R4 event beats clear", 4'h0, 32'h0000_0430);
        bus_wr(4'h0, 4'h3, 32'h0000_0430);
        rd_chk("R4 clear all set bits", 4'h0, 32'h0);
        bus_wr(4'h5, 4'h3, 32'h0000_FFFF);
        rd_chk("R2 misaligned write ignored", 4'h4, 32'h0000_0001);
        rd_chk("R2 misaligned read is zero", 4'h5, 32'h0);
    endtask

    task automatic t_bytes();
        bus_wr(4'h0, 4'h4, 32'h00AA_0000);
        bus_wr(4'h0, 4'h8, 32'h5500_0000);
        rd_chk("R3 enable byte lanes", 4'h0, 32'h55AA_0000);
        bus_wr(4'h4, 4'h2, 32'h0000_2000);
        rd_chk("R3 control high byte", 4'h4, 32'h0000_2001);
        bus_wr(4'h4, 4'h3, 32'h0000_0001);
        rd_chk("R3 control word write", 4'h4, 32'h0000_0001);
    endtask

    task automatic t_dword_sci();
        pulse_pwr(); pulse_gbl();
        bus_wr(4'h0, 4'hF, 32'h0421_0100);
        rd_chk("R6 dword clears status and loads enable", 4'h0, 32'h0421_0020);
        sci_chk("R9 enabled global event raises sci", 1'b1);
        bus_wr(4'h4, 4'h3, 32'h0);
        sci_chk("R9 sci gated by control bit 0", 1'b0);
        bus_wr(4'h4, 4'h3, 32'h1);
        sci_chk("R9 sci returns with control bit 0", 1'b1);
        bus_wr(4'h0, 4'h1, 32'h20);
        sci_chk("R9 sci drops after clear", 1'b0);
        bus_wr(4'h0, 4'hC, 32'hFFFF_0000);
        pulse_bm();
        rd_chk("R5 bus master status", 4'h0, 32'hFFFF_0010);
        sci_chk("R9 bus master never raises sci", 1'b0);
        pulse_rtc();
        sci_chk("R9 rtc raises sci", 1'b1);
        bus_wr(4'h0, 4'h3, 32'hFFFF);
        sci_chk("R9 sci low after full clear", 1'b0);
        ticks(64);
        sci_chk("R8 timer overflow raises sci", 1'b1);
    endtask

    initial begin
        rst_n = 0; io_sel = 0; io_wr = 0; io_addr = 0; io_be = 0; io_wdata = 0;
        tmr_tick = 0; evt_pwrbtn = 0; evt_rtc = 0; evt_busmst = 0; evt_gbl_rls = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timer();
        t_events();
        t_w1c();
        t_bytes();
        t_dword_sci();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule